// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flags

This block is the arithmetic core of a small 16-bit processor. It takes two operands and a four-bit operation code and returns a result in the same cycle. It also returns the flag values that this result would produce. A four-bit status register holds the negative, zero, carry and overflow flags. The register captures those flag values on a rising clock edge when the caller asks for it. Addition and subtraction take the stored carry as an implicit carry-in, so multi-word sums can be chained. The logic operations clear the carry, so a program can run a single AND to start a fresh sum.

Software can also load the status register directly from the low four bits of a 16-bit word. The register is always visible as a zero-extended word. The result write enable is low only for compare, which updates the flags and writes nothing. Instruction decode, the register file and memory are outside this block.

Top module: `alu16_flags`

## Requirements
- R1: A clock edge with rst_n low clears the status register to 0000. This holds even when a flag load is requested at the same time.
- R2: Code 0 (add) gives result = a + b + C, where C is the stored carry. The next C is the unsigned carry out of bit 15. The next V is set when the signed sum a + b + C is outside -32768..32767.
- R3: Code 1 (subtract) gives result = a - b - C. The next C is set when the unsigned difference is negative (borrow). The next V is set when the signed difference is out of range.
- R4: Code 15 (compare) computes a - b with no carry-in and sets C and V as in R3. Its result_we is 0. Every other code gives result_we = 1.
- R5: Code 2 returns the low 16 bits and code 3 the high 16 bits of the signed 32-bit product a*b. Both clear C and V.
- R6: Codes 4 and 5 divide signed operands, truncating toward zero, and return the quotient and the remainder. The remainder takes the sign of the dividend. For -32768 / -1 the quotient is 0x8000, the remainder is 0, and V is set. Otherwise V is clear. C is always clear.
- R7: When b is zero, code 4 returns 0xFFFF and code 5 returns a, with V set and C clear.
- R8: Codes 6 AND, 7 OR, 8 XOR and 9 NOT operate bitwise. NOT complements a and ignores b. All four clear C and V.
- R9: Codes 10 shift left logical, 11 shift right logical, 12 shift right arithmetic, 13 rotate left and 14 rotate right move a by b[3:0] places. The upper bits of b are ignored. All five clear C and V.
- R10: For every code, the next N equals bit 15 of the result, and the next Z is 1 exactly when the result is zero.
- R11: The flag layout is N bit 3, Z bit 2, C bit 1, V bit 0. With flag_we high and flag_load low, a rising edge stores next_flags. With both low, the register holds.
- R12: flag_load high stores flag_load_val[3:0] and takes priority over flag_we. flags_word returns the register zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | First operand (dividend, shifted value) |
| opnd_b | input | 16 | Second operand (divisor, shift amount in [3:0]) |
| flag_we | input | 1 | Store next_flags on the coming edge |
| flag_load | input | 1 | Store flag_load_val[3:0] on the coming edge, overriding flag_we |
| flag_load_val | input | 16 | Word whose low four bits are loaded into the flags |
| result | output | 16 | Operation result, same cycle |
| result_we | output | 1 | Result should be written back; low for compare |
| next_flags | output | 4 | Flags the current operation produces |
| flags_q | output | 4 | Stored status register |
| flags_word | output | 16 | Stored status register zero-extended |

## Verification
The only internal state is the four-bit flag register. An error in it shows at flags_q and flags_word on the cycle right after the edge that wrote it. When the bad bit is the carry, it also shows in the same cycle as a result of add or subtract that is off by one. The reference model tracks the expected flags on every cycle and compares the register and all combinational outputs before each edge. A wrong flag is therefore reported within one cycle of being stored. The runs chain carries through add, subtract and AND, so a carry that was lost or left stale is visible in the arithmetic results.

// File: rtl/alu16_pkg.sv
// Package alu16_pkg
// Shared operation codes and the flag record for the 16-bit ALU.
// Assumes the flag layout N[3] Z[2] C[1] V[0].
package alu16_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_MULH = 4'd3,
        OP_DIV  = 4'd4,
        OP_MOD  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_EOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_LSL  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ASR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14,
        OP_CMP  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu16_addsub.sv
// Module alu16_addsub
// Adds or subtracts two operands with an explicit carry or borrow input.
// Computes the result, carry/borrow out, signed overflow, N and Z.
// Assumes the caller forces carry_in low for compare.
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_in,
    input  logic         is_sub,
    output logic [W-1:0] res,
    output flags_t       fl
);

    localparam int WX = W + 1;

    logic [WX-1:0] uwide;
    logic [WX-1:0] swide;
    logic [WX-1:0] cin_x;

    assign cin_x = {{W{1'b0}}, carry_in};

    // Unsigned sum or difference, one bit wider to expose carry or borrow
    always_comb begin
        if (is_sub) begin
            uwide = {1'b0, a} - {1'b0, b} - cin_x;
        end else begin
            uwide = {1'b0, a} + {1'b0, b} + cin_x;
        end
    end

    // Sign-extended sum or difference used only for overflow detection
    always_comb begin
        if (is_sub) begin
            swide = {a[W-1], a} - {b[W-1], b} - cin_x;
        end else begin
            swide = {a[W-1], a} + {b[W-1], b} + cin_x;
        end
    end

    assign res  = uwide[W-1:0];

    // Flag values for this unit's result
    always_comb begin
        fl.n = uwide[W-1];
        fl.z = (uwide[W-1:0] == '0);
        fl.c = uwide[W];
        fl.v = swide[W] ^ swide[W-1];
    end

endmodule

// File: rtl/alu16_muldiv.sv
// Module alu16_muldiv
// Signed multiply (low or high half), divide and remainder.
// Divide by zero returns all ones (quotient) or the dividend (remainder)
// and sets V. The one signed quotient overflow also sets V.
module alu16_muldiv
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       fl
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod;
    logic signed [W:0]    sa;
    logic signed [W:0]    sb;
    logic signed [W:0]    sb_safe;
    logic signed [W:0]    quo;
    logic signed [W:0]    rem;
    logic                 div_zero;
    logic                 quo_ovf;
    logic                 unused_rem;

    assign prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

    assign sa       = $signed({a[W-1], a});
    assign sb       = $signed({b[W-1], b});
    assign div_zero = (b == '0);
    assign sb_safe  = div_zero ? (W+1)'(1) : sb;
    assign quo      = sa / sb_safe;
    assign rem      = sa % sb_safe;
    assign quo_ovf  = quo[W] ^ quo[W-1];
    assign unused_rem = rem[W];

    // Result and V selection per operation
    always_comb begin
        res  = '0;
        fl.v = 1'b0;
        unique case (op)
            OP_MUL:  res = prod[W-1:0];
            OP_MULH: res = prod[PW-1:W];
            OP_DIV: begin
                res  = div_zero ? '1 : quo[W-1:0];
                fl.v = div_zero | quo_ovf;
            end
            OP_MOD: begin
                res  = div_zero ? a : rem[W-1:0];
                fl.v = div_zero | quo_ovf;
            end
            default: res = '0;
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.c = 1'b0;
    end

endmodule

// File: rtl/alu16_bitops.sv
// Module alu16_bitops
// Bitwise logic, shifts and rotates. The shift count is the low
// log2(W) bits of b. Clears C and V; N and Z come from the result.
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       fl
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0]        sh;
    logic [2*W-1:0]        rol_w;
    logic [2*W-1:0]        ror_w;
    logic signed [W-1:0]   a_s;
    logic [W-1:0]          asr_r;
    logic                  unused_rot;

    assign sh    = b[SHW-1:0];
    assign rol_w = {a, a} << sh;
    assign ror_w = {a, a} >> sh;
    assign a_s   = $signed(a);
    assign asr_r = a_s >>> sh;
    assign unused_rot = ^{rol_w[W-1:0], ror_w[2*W-1:W]};

    // Per-operation bit manipulation
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_EOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_LSL:  res = a << sh;
            OP_LSR:  res = a >> sh;
            OP_ASR:  res = asr_r;
            OP_ROL:  res = rol_w[2*W-1:W];
            OP_ROR:  res = ror_w[W-1:0];
            default: res = '0;
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.c = 1'b0;
        fl.v = 1'b0;
    end

endmodule

// File: rtl/alu16_flagreg.sv
// Module alu16_flagreg
// Four-bit status register with synchronous active-low reset.
// A direct load takes priority over the normal flag write.
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              load,
    input  logic [FLAG_W-1:0] load_val,
    input  logic [FLAG_W-1:0] d,
    output logic [FLAG_W-1:0] q
);

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (we) begin
            q <= d;
        end
    end

    // R12: direct load lands on the next edge
    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));

    // R11: write without load captures the computed flags
    a_r11_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !load) |=> (q == $past(d)));

    // R11: no write, no load keeps the register
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !load) |=> $stable(q));

endmodule

// File: rtl/alu16_flags.sv
// Module alu16_flags (top)
// Single-cycle ALU with a registered NZCV status register.
// Add and subtract use the stored carry as carry-in; compare does not.
// Assumes W >= 4 so the flags fit inside one word.
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic              flag_we,
    input  logic              flag_load,
    input  logic [W-1:0]      flag_load_val,
    output logic [W-1:0]      result,
    output logic              result_we,
    output logic [FLAG_W-1:0] next_flags,
    output logic [FLAG_W-1:0] flags_q,
    output logic [W-1:0]      flags_word
);

    alu_op_e      op;
    flags_t       stored;
    logic         is_arith;
    logic         is_muldiv;
    logic         as_cin;
    logic [W-1:0] as_res, md_res, bo_res;
    flags_t       as_fl, md_fl, bo_fl;
    logic         unused_ld;

    assign op        = alu_op_e'(op_sel);
    assign stored    = flags_t'(flags_q);
    assign is_arith  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    assign is_muldiv = (op == OP_MUL) || (op == OP_MULH) ||
                       (op == OP_DIV) || (op == OP_MOD);
    assign as_cin    = (op == OP_CMP) ? 1'b0 : stored.c;
    assign unused_ld = ^flag_load_val[W-1:FLAG_W];

    alu16_addsub #(.W(W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .carry_in (as_cin),
        .is_sub   (op != OP_ADD),
        .res      (as_res),
        .fl       (as_fl)
    );

    alu16_muldiv #(.W(W)) u_muldiv (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (md_res),
        .fl  (md_fl)
    );

    alu16_bitops #(.W(W)) u_bitops (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (bo_res),
        .fl  (bo_fl)
    );

    // Select the active unit's result and flags
    always_comb begin
        if (is_arith) begin
            result     = as_res;
            next_flags = as_fl;
        end else if (is_muldiv) begin
            result     = md_res;
            next_flags = md_fl;
        end else begin
            result     = bo_res;
            next_flags = bo_fl;
        end
    end

    assign result_we = (op != OP_CMP);

    alu16_flagreg u_flagreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (flag_we),
        .load     (flag_load),
        .load_val (flag_load_val[FLAG_W-1:0]),
        .d        (next_flags),
        .q        (flags_q)
    );

    assign flags_word = {{(W-FLAG_W){1'b0}}, flags_q};

    // R10: Z tracks a zero result whichever unit produced it
    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        next_flags[2] == (result == '0));

    // R10: N tracks the result sign bit
    a_r10_neg: assert property (@(posedge clk) disable iff (!rst_n)
        next_flags[3] == result[W-1]);

    // R7: divide by zero gives all ones and overflow
    a_r7_div0: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DIV && opnd_b == '0) |-> (result == '1 && next_flags[0]));

    // R2: a carry out with no carry in means the sum wrapped below a
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && !flags_q[1] && next_flags[1]) |-> (result < opnd_a));

    // R8, R9: bit operations never report carry or overflow
    a_r8_bitops_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_arith && !is_muldiv) |-> (next_flags[1:0] == 2'b00));

endmodule

// File: tb/tb_alu16_flags.sv
`timescale 1ns/1ps
module tb_alu16_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        flag_we = 1'b0;
    logic        flag_load = 1'b0;
    logic [15:0] flag_load_val = '0;
    logic [15:0] result;
    logic        result_we;
    logic [3:0]  next_flags;
    logic [3:0]  flags_q;
    logic [15:0] flags_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [3:0] mflags = 4'h0;

    always #2 clk = ~clk;

    alu16_flags dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_we(flag_we), .flag_load(flag_load),
        .flag_load_val(flag_load_val), .result(result), .result_we(result_we),
        .next_flags(next_flags), .flags_q(flags_q), .flags_word(flags_word)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2 add";
            4'd1: return "R3 sub";
            4'd2, 4'd3: return "R5 mul";
            4'd4, 4'd5: return "R6/R7 div";
            4'd6, 4'd7, 4'd8, 4'd9: return "R8 logic";
            4'd15: return "R4 cmp";
            default: return "R9 shift";
        endcase
    endfunction

    // Behavioural reference: returns {we, result, N, Z, C, V}
    function automatic logic [20:0] ref_eval(input logic [3:0] op, input logic [15:0] a,
                                             input logic [15:0] b, input logic [3:0] fl);
        int sa, sb, cin, t;
        longint p;
        logic [15:0] r;
        logic [31:0] dbl;
        logic [3:0] amt;
        logic c, v, we;
        sa = int'($signed(a));
        sb = int'($signed(b));
        cin = int'(fl[1]);
        amt = b[3:0];
        p = longint'(sa) * longint'(sb);
        we = 1'b1; c = 1'b0; v = 1'b0; r = '0;
        case (op)
            4'd0: begin
                t = int'(a) + int'(b) + cin; r = t[15:0]; c = (t > 65535);
                t = sa + sb + cin; v = (t > 32767) || (t < -32768);
            end
            4'd1, 4'd15: begin
                if (op == 4'd15) cin = 0;
                t = int'(a) - int'(b) - cin; r = t[15:0]; c = (t < 0);
                t = sa - sb - cin; v = (t > 32767) || (t < -32768);
                we = (op != 4'd15);
            end
            4'd2: r = p[15:0];
            4'd3: r = p[31:16];
            4'd4: begin
                if (b == 0) begin r = 16'hFFFF; v = 1'b1; end
                else begin t = sa / sb; r = t[15:0]; v = (t > 32767); end
            end
            4'd5: begin
                if (b == 0) begin r = a; v = 1'b1; end
                else begin t = sa % sb; r = t[15:0]; v = (sa == -32768) && (sb == -1); end
            end
            4'd6: r = a & b;
            4'd7: r = a | b;
            4'd8: r = a ^ b;
            4'd9: r = ~a;
            4'd10: r = a << amt;
            4'd11: r = a >> amt;
            4'd12: begin t = sa >>> amt; r = t[15:0]; end
            4'd13: begin dbl = {a, a} << amt; r = dbl[31:16]; end
            default: begin dbl = {a, a} >> amt; r = dbl[15:0]; end
        endcase
        return {we, r, r[15], (r == 16'h0), c, v};
    endfunction

    task automatic step(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic we, input logic ld, input logic [15:0] ldv);
        logic [20:0] e;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        flag_we = we; flag_load = ld; flag_load_val = ldv;
        #1;
        e = ref_eval(op, a, b, mflags);
        chk(tag_of(op), result, e[19:4]);
        chk("R4 result_we", {15'b0, result_we}, {15'b0, e[20]});
        chk("R10 next_flags", {12'b0, next_flags}, {12'b0, e[3:0]});
        chk("R11 flags_q", {12'b0, flags_q}, {12'b0, mflags});
        chk("R12 flags_word", flags_word, {12'b0, mflags});
        if (ld) mflags = ldv[3:0];
        else if (we) mflags = e[3:0];
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset wins over a requested load
        flag_load = 1'b1; flag_load_val = 16'h000F;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset flags_q", {12'b0, flags_q}, 16'h0);
        chk("R1 reset flags_word", flags_word, 16'h0);
        @(negedge clk);
        flag_load = 1'b0;
        rst_n = 1'b1;

        // R12: load beats write, upper bits discarded
        step(4'd0, 16'h1, 16'h1, 1'b1, 1'b1, 16'hFFF2);
        // R2: carry-in from stored C, wrap to zero
        step(4'd0, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'h0);
        step(4'd0, 16'h7FFF, 16'h0000, 1'b1, 1'b0, 16'h0);
        // R8: AND clears carry, then a clean add
        step(4'd6, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0);
        step(4'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 16'h0);
        // R3: borrow chain
        step(4'd1, 16'h0000, 16'h0001, 1'b1, 1'b0, 16'h0);
        step(4'd1, 16'h0000, 16'h7FFF, 1'b1, 1'b0, 16'h0);
        step(4'd1, 16'h8000, 16'h0000, 1'b1, 1'b0, 16'h0);
        // R4: compare ignores carry, no write
        step(4'd15, 16'h1234, 16'h1234, 1'b1, 1'b0, 16'h0);
        step(4'd15, 16'h0001, 16'h0002, 1'b1, 1'b0, 16'h0);
        // R5: products
        step(4'd2, 16'hFFFF, 16'h0002, 1'b1, 1'b0, 16'h0);
        step(4'd3, 16'hFFFF, 16'h0002, 1'b1, 1'b0, 16'h0);
        step(4'd3, 16'h8000, 16'h8000, 1'b1, 1'b0, 16'h0);
        // R6: signed division and overflow corner
        step(4'd4, 16'hFFF9, 16'h0002, 1'b1, 1'b0, 16'h0);
        step(4'd5, 16'hFFF9, 16'h0002, 1'b1, 1'b0, 16'h0);
        step(4'd4, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 16'h0);
        step(4'd5, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 16'h0);
        // R7: divide by zero
        step(4'd4, 16'h1234, 16'h0000, 1'b1, 1'b0, 16'h0);
        step(4'd5, 16'h1234, 16'h0000, 1'b1, 1'b0, 16'h0);
        // R8: NOT ignores b
        step(4'd9, 16'h00FF, 16'hABCD, 1'b1, 1'b0, 16'h0);
        // R9: upper bits of b ignored, extreme counts
        step(4'd10, 16'h8001, 16'hFFF0, 1'b1, 1'b0, 16'h0);
        step(4'd12, 16'h8000, 16'h000F, 1'b1, 1'b0, 16'h0);
        step(4'd13, 16'h8001, 16'h0011, 1'b1, 1'b0, 16'h0);
        step(4'd14, 16'h8001, 16'h00F1, 1'b1, 1'b0, 16'h0);
        step(4'd11, 16'h8000, 16'h000F, 1'b1, 1'b0, 16'h0);
        // R11: hold with write disabled
        step(4'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'h0);
        step(4'd6, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0);

        // Mixed stimulus against the reference model
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (($urandom % 8) == 0) rb = 16'($urandom % 3) - 16'd1;
            if (($urandom % 16) == 0) ra = 16'h8000;
            step(4'($urandom), ra, rb, ($urandom % 4) != 0,
                 ($urandom % 16) == 0, 16'($urandom));
        end

        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule